// File: doc/BRIEF.md
# Serial Receive Queue with Idle Timeout

This block sits behind the bit-level deserializer of a fast serial port. The port uses a fixed frame of 8 data bits, no parity and one stop bit. Each finished character arrives as a one-cycle strobe with its byte and two per-character flags: a framing error flag and a line-break flag. The block stores the character and its flags in a 64-entry first-in first-out queue.

The processor side sees the head of the queue as one 11-bit word. A one-cycle read strobe removes that entry. The block also reports the fill count and two service requests:
- a level request that stays high while the fill is at or above a selectable depth;
- a timeout request raised when data has been waiting for a selectable number of character times with no activity.

A character that arrives while the queue is full is dropped and sets a sticky overrun flag. A separate pulse clears that flag. The deserializer supplies a one-cycle `char_tick` pulse once per character time, and the idle timer counts those pulses.

Top module: `serial_rx_queue`

## Requirements
- R1: The read word `rd_word` carries the head character's byte in bits 7:0, a zero in bit 8, its framing-error flag in bit 9 and its break flag in bit 10 whenever the queue holds data.
- R2: While the queue is empty, `rd_word` is 11'h100 (bit 8 set, all other bits zero). A read strobe on an empty queue removes nothing, so the next character written is the next one read.
- R3: The queue holds up to 64 characters and returns them in arrival order. `fill_level` (8 bits) equals the number of stored characters, and it changes one cycle after a write or a read.
- R4: A character that arrives while the queue holds 64 entries is discarded, and `overrun` is set on the next cycle. The flag stays set until a cycle with `ovr_clr` high. If a drop and a clear fall in the same cycle, the drop wins.
- R5: `trig_sel` codes 0, 1, 2, 3, 4 and 5 select depths of 1, 4, 8, 16, 32 and 48 characters. Codes 6 and 7 also select 48. `trig_req` is high exactly while `fill_level` is at or above the selected depth.
- R6: `tmo_sel` code 0 disables the timeout. Codes 1, 2 and 3 raise `tmo_req` after 4, 8 and 16 `char_tick` pulses counted with no write and no read while the queue holds data.
- R7: The idle count restarts on every accepted character and on every read, and it does not advance while the queue is empty. `tmo_req` is low while the queue is empty and in the cycle after a restart.
- R8: After reset the queue is empty, `fill_level` is 0 and `trig_req`, `tmo_req` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a character is complete |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error seen on this character |
| rx_brk | input | 1 | Line break seen on this character |
| char_tick | input | 1 | One-cycle pulse per character time |
| rd_en | input | 1 | Read strobe: removes the head entry |
| rd_word | output | 11 | Head word: break, framing error, empty and byte |
| fill_level | output | 8 | Number of stored characters |
| trig_sel | input | 3 | Trigger depth select |
| tmo_sel | input | 2 | Idle timeout select |
| trig_req | output | 1 | Fill is at or above the selected depth |
| tmo_req | output | 1 | Data has waited past the idle limit |
| ovr_clr | input | 1 | Clears the overrun flag |
| overrun | output | 1 | Sticky flag: a character was dropped |

## Verification
The hardest state to reach from the ports is the timer window just before expiry. Reaching it needs data in the queue and exactly one tick fewer than the limit. Then a restart event has to land between that tick and the expiring one.

The stimulus fills the queue with one character and issues `char_tick` pulses one at a time. Before the final pulse it writes a second character, or reads one. It then confirms that `tmo_req` needs a full new window.

The overrun corner is reached by writing 64 distinct characters and then one more. A full drain follows, so the bench can confirm that the extra character never entered the queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic [7:0] data;
  } rx_char_t;

  // Trigger depth for a 3-bit select code; codes above 5 saturate at 48.
  function automatic logic [6:0] trig_depth(input logic [2:0] sel);
    case (sel)
      3'd0:    trig_depth = 7'd1;
      3'd1:    trig_depth = 7'd4;
      3'd2:    trig_depth = 7'd8;
      3'd3:    trig_depth = 7'd16;
      3'd4:    trig_depth = 7'd32;
      default: trig_depth = 7'd48;
    endcase
  endfunction

  // Idle limit in character times; 0 means the timeout is off.
  function automatic logic [4:0] idle_limit(input logic [1:0] sel);
    case (sel)
      2'd1:    idle_limit = 5'd4;
      2'd2:    idle_limit = 5'd8;
      2'd3:    idle_limit = 5'd16;
      default: idle_limit = 5'd0;
    endcase
  endfunction

  // Processor-side word layout: {brk, ferr, empty, data}.
  function automatic logic [10:0] pack_word(input rx_char_t c, input logic empty);
    if (empty) pack_word = 11'h100;
    else       pack_word = {c.brk, c.ferr, 1'b0, c.data};
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  rx_char_t      push_char,
  input  logic          pop,
  output rx_char_t      head,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          push_drop
);

  rx_char_t      mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  assign empty     = (count == '0);
  assign full      = (count == CW'(DEPTH));
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign pop_ok    = pop && !empty;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (count == $past(count) + 1'b1));

  assert_empty_read_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> ($stable(rd_ptr) && count == '0));

endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic       empty,
  input  logic [1:0] sel,
  output logic       tmo_req
);

  logic [4:0] limit;
  logic [4:0] idle_cnt;

  assign limit = idle_limit(sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      idle_cnt <= '0;
    else if (restart || empty)       idle_cnt <= '0;
    else if (tick && idle_cnt < limit) idle_cnt <= idle_cnt + 1'b1;
  end

  assign tmo_req = (limit != '0) && (idle_cnt >= limit) && !empty;

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && $stable(sel)) |=> !tmo_req);

  assert_rise_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tmo_req) && $stable(sel) && $stable(empty)) |-> $past(tick));

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic [2:0]    trig_sel,
  input  logic          drop,
  input  logic          ovr_clr,
  output logic          trig_req,
  output logic          overrun
);

  assign trig_req = int'(count) >= int'(trig_depth(trig_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       overrun <= 1'b0;
    else if (drop)    overrun <= 1'b1;
    else if (ovr_clr) overrun <= 1'b0;
  end

  assert_trig_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_req |-> (count != '0));

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(overrun) && !$past(ovr_clr)) |-> overrun);

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_ferr,
  input  logic             rx_brk,
  input  logic             char_tick,
  input  logic             rd_en,
  output logic [10:0]      rd_word,
  output logic [LVL_W-1:0] fill_level,
  input  logic [2:0]       trig_sel,
  input  logic [1:0]       tmo_sel,
  output logic             trig_req,
  output logic             tmo_req,
  input  logic             ovr_clr,
  output logic             overrun
);

  localparam int CW = $clog2(DEPTH) + 1;

  rx_char_t      in_char, head;
  logic          empty, full, push_ok, pop_ok, push_drop;
  logic [CW-1:0] count;
  logic          restart;

  assign in_char = '{brk: rx_brk, ferr: rx_ferr, data: rx_data};

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(rx_valid), .push_char(in_char), .pop(rd_en),
    .head(head), .empty(empty), .full(full), .count(count),
    .push_ok(push_ok), .pop_ok(pop_ok), .push_drop(push_drop)
  );

  assign restart = push_ok || pop_ok;

  rxq_idle_timer u_timer (
    .clk(clk), .rst_n(rst_n), .tick(char_tick), .restart(restart),
    .empty(empty), .sel(tmo_sel), .tmo_req(tmo_req)
  );

  rxq_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .count(count), .trig_sel(trig_sel),
    .drop(push_drop), .ovr_clr(ovr_clr), .trig_req(trig_req), .overrun(overrun)
  );

  assign rd_word    = pack_word(head, empty);
  assign fill_level = LVL_W'(count);

  assert_drop_sets_ovr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && full) |=> overrun);

  assert_empty_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[8] == (fill_level == '0));

endmodule

// File: tb/serial_rx_queue_tb.sv
module serial_rx_queue_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        char_tick = 1'b0, rd_en = 1'b0, ovr_clr = 1'b0;
  logic [2:0]  trig_sel = '0;
  logic [1:0]  tmo_sel = '0;
  logic [10:0] rd_word;
  logic [7:0]  fill_level;
  logic        trig_req, tmo_req, overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_rx_queue u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk), .char_tick(char_tick), .rd_en(rd_en),
    .rd_word(rd_word), .fill_level(fill_level), .trig_sel(trig_sel),
    .tmo_sel(tmo_sel), .trig_req(trig_req), .tmo_req(tmo_req),
    .ovr_clr(ovr_clr), .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int depth_of(input int s);
    int t[8] = '{1, 4, 8, 16, 32, 48, 48, 48};
    return t[s];
  endfunction

  task automatic put(input logic [7:0] d, input logic fe, input logic bk);
    @(negedge clk);
    rx_valid = 1; rx_data = d; rx_ferr = fe; rx_brk = bk;
    @(negedge clk);
    rx_valid = 0; rx_ferr = 0; rx_brk = 0;
  endtask

  task automatic take(output logic [10:0] w);
    @(negedge clk);
    w = rd_word; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); char_tick = 1;
      @(negedge clk); char_tick = 0;
    end
  endtask

  task automatic drain();
    logic [10:0] w;
    while (fill_level != 0) take(w);
  endtask

  task automatic t_reset();
    chk("R8 fill", fill_level, 0);
    chk("R8 word", rd_word, 'h100);
    chk("R8 trig", trig_req, 0);
    chk("R8 tmo", tmo_req, 0);
    chk("R8 ovr", overrun, 0);
  endtask

  task automatic t_format();
    logic [10:0] w;
    put(8'hA5, 1, 0);
    put(8'h3C, 0, 1);
    put(8'h7E, 1, 1);
    chk("R3 fill after 3", fill_level, 3);
    take(w); chk("R1 ferr word", w, 'h2A5);
    take(w); chk("R1 brk word", w, 'h43C);
    take(w); chk("R1 both flags", w, 'h67E);
    chk("R3 fill drained", fill_level, 0);
  endtask

  task automatic t_empty_read();
    logic [10:0] w;
    take(w); chk("R2 empty word", w, 'h100);
    chk("R2 fill stays 0", fill_level, 0);
    put(8'h11, 0, 0);
    take(w); chk("R2 next char after empty read", w, 'h011);
    chk("R2 word after drain", rd_word, 'h100);
  endtask

  task automatic t_trigger();
    for (int s = 0; s < 8; s++) begin
      trig_sel = 3'(s);
      for (int k = 0; k < depth_of(s) - 1; k++) put(8'(k), 0, 0);
      @(negedge clk);
      chk($sformatf("R5 below depth sel %0d", s), trig_req, 0);
      put(8'hFF, 0, 0);
      chk($sformatf("R5 at depth sel %0d", s), trig_req, 1);
      drain();
      chk($sformatf("R5 low after drain sel %0d", s), trig_req, 0);
    end
    trig_sel = 0;
  endtask

  task automatic t_overrun();
    logic [10:0] w;
    for (int k = 0; k < 64; k++) put(8'(k + 8'h40), 0, 0);
    chk("R3 fill at 64", fill_level, 64);
    chk("R4 no overrun yet", overrun, 0);
    put(8'hEE, 0, 0);
    chk("R4 overrun set", overrun, 1);
    chk("R4 fill unchanged", fill_level, 64);
    for (int k = 0; k < 64; k++) begin
      take(w);
      if (k == 0 || k == 63 || w != 11'(k + 'h40))
        chk($sformatf("R3 order entry %0d", k), w, k + 'h40);
    end
    chk("R4 extra char dropped", rd_word, 'h100);
    chk("R4 overrun sticky", overrun, 1);
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    chk("R4 overrun cleared", overrun, 0);
  endtask

  task automatic t_timeout();
    logic [10:0] w;
    int lim;
    for (int s = 1; s < 4; s++) begin
      tmo_sel = 2'(s);
      lim = 4 << (s - 1);
      put(8'h21, 0, 0);
      ticks(lim - 1);
      chk($sformatf("R6 before limit sel %0d", s), tmo_req, 0);
      ticks(1);
      chk($sformatf("R6 at limit sel %0d", s), tmo_req, 1);
      put(8'h22, 0, 0);
      chk($sformatf("R7 push restarts sel %0d", s), tmo_req, 0);
      ticks(lim - 1);
      take(w);
      chk($sformatf("R7 read restarts sel %0d", s), tmo_req, 0);
      ticks(lim - 1);
      chk($sformatf("R7 new window short sel %0d", s), tmo_req, 0);
      ticks(1);
      chk($sformatf("R7 new window full sel %0d", s), tmo_req, 1);
      take(w);
      chk($sformatf("R7 low when empty sel %0d", s), tmo_req, 0);
    end
    ticks(20);
    chk("R7 no count while empty", tmo_req, 0);
    put(8'h33, 0, 0);
    chk("R7 fresh after empty period", tmo_req, 0);
    ticks(3);
    chk("R7 empty period not counted", tmo_req, 0);
    drain();
    tmo_sel = 0;
    put(8'h44, 0, 0);
    ticks(20);
    chk("R6 disabled code 0", tmo_req, 0);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_format();
    t_empty_read();
    t_trigger();
    t_overrun();
    t_timeout();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule